// File: doc/BRIEF.md
# Accumulator ALU with Status Word

An 8-bit arithmetic and logic unit built around an accumulator, a second operand register (B) and a byte-wide status word. Each cycle in which `op_valid` is high, the unit applies the operation selected by `op_code` to the accumulator and the byte on `op_operand`. The operations are add, add with carry, subtract with borrow, AND, OR, XOR, increment, decrement and load. The result is written back into the accumulator on the next clock edge. Arithmetic operations update the carry, auxiliary-carry and overflow flags. The parity flag always follows the current accumulator contents.

The accumulator, B and the status word can also be reached over a small byte-wide register bus. Reads are combinational. Writes take effect on the clock edge. The two register-bank select bits of the status word are driven out on `bank_sel`, so a neighbouring register file can pick its bank. The status word uses this fixed layout, from bit 7 down to bit 0: carry, auxiliary carry, user flag F0, bank select high, bank select low, overflow, a spare user bit, and parity.

Top module: `acc_alu_core`

## Requirements
- R1: While `rst_n` is low, and after its release, the accumulator, B and the status word all read 0x00. `bank_sel` reads 0.
- R2: Opcode 0 (add) writes `(A + operand) mod 256` into A. Opcode 1 (add with carry) writes `(A + operand + CY) mod 256`. Both set CY (status bit 7) exactly when the unsigned sum exceeds 255.
- R3: For add and add with carry, AC (status bit 6) is set exactly when the low nibbles, plus the carry in, exceed 15. For subtract with borrow, AC is set exactly when `A[3:0] - operand[3:0] - CY` is negative.
- R4: For opcodes 0, 1 and 2, OV (status bit 2) is set exactly when the true signed two's-complement result lies outside -128..127.
- R5: Opcode 2 (subtract with borrow) writes `(A - operand - CY) mod 256` into A. It sets CY exactly when that difference, taken as an integer, is negative.
- R6: Opcodes 3, 4 and 5 write `A & operand`, `A | operand` and `A ^ operand` into A. They leave status bits 7..1 unchanged.
- R7: Opcode 6 (increment) and opcode 7 (decrement) wrap modulo 256. Opcode 8 loads the operand into A. All three leave status bits 7..1 unchanged. Opcodes 9..15, and any cycle with `op_valid` low, change neither A nor the status word.
- R8: Status bit 0 (P) is 1 exactly when the accumulator, as it reads on `acc_q` in the same cycle, holds an odd number of 1 bits.
- R9: Bus address 0xD0 selects the status word, 0xE0 the accumulator and 0xF0 the B register. `bus_rdata` shows the addressed register in the same cycle. Other addresses read 0x00, and writes to them change nothing.
- R10: A bus write to 0xD0 replaces status bits 7..1 with `bus_wdata[7:1]` on the next edge. P ignores the written bit 0.
- R11: `bank_sel` always equals status bits 4..3.
- R12: When a bus write and an operation target the same register in one cycle, the bus write wins for that register. A bus write to the status word overrides the flag updates of that operation, while the operation's accumulator result is still written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | Operation strobe for this cycle |
| op_code | input | 4 | Operation select (0 add … 8 load) |
| op_operand | input | 8 | Second operand of the operation |
| bus_addr | input | 8 | Register bus address |
| bus_we | input | 1 | Register bus write enable |
| bus_wdata | input | 8 | Register bus write data |
| bus_rdata | output | 8 | Register bus read data (combinational) |
| acc_q | output | 8 | Current accumulator |
| b_q | output | 8 | Current B register |
| psw_q | output | 8 | Current status word including parity |
| bank_sel | output | 2 | Register-bank select bits of the status word |

## Verification
On every cycle, the assertions check the following:
- parity agrees with the accumulator's bit count;
- flags stay frozen across logical, increment, decrement, load and idle cycles;
- a status-word write lands on bits 7..1;
- add with carry produces the accumulator value implied by the previous CY;
- bus writes take precedence over the operation result.

Only the bench's scenarios can show that the carry, auxiliary-carry and overflow values are correct across the nibble and sign boundaries. The same holds for the borrow behaviour of subtraction, address decoding and unmapped addresses, and the combined effect of a status-word write arriving alongside an arithmetic operation. Those scenarios are compared, clock by clock, against a behavioural integer model.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

  localparam logic [3:0] OP_ADD  = 4'd0;
  localparam logic [3:0] OP_ADDC = 4'd1;
  localparam logic [3:0] OP_SUBB = 4'd2;
  localparam logic [3:0] OP_AND  = 4'd3;
  localparam logic [3:0] OP_OR   = 4'd4;
  localparam logic [3:0] OP_XOR  = 4'd5;
  localparam logic [3:0] OP_INC  = 4'd6;
  localparam logic [3:0] OP_DEC  = 4'd7;
  localparam logic [3:0] OP_LOAD = 4'd8;

  // Status word bit positions (decoded by neighbours, so fixed)
  localparam int SW_CY  = 7;
  localparam int SW_AC  = 6;
  localparam int SW_F0  = 5;
  localparam int SW_BK1 = 4;
  localparam int SW_BK0 = 3;
  localparam int SW_OV  = 2;
  localparam int SW_UD  = 1;
  localparam int SW_P   = 0;

  typedef struct packed {
    logic cy;
    logic ac;
    logic ov;
  } arith_flags_t;

  function automatic logic op_is_arith(input logic [3:0] op);
    return (op == OP_ADD) || (op == OP_ADDC) || (op == OP_SUBB);
  endfunction

  function automatic logic op_is_logic(input logic [3:0] op);
    return (op == OP_AND) || (op == OP_OR) || (op == OP_XOR);
  endfunction

  function automatic logic op_writes_acc(input logic [3:0] op);
    return op <= OP_LOAD;
  endfunction

endpackage

// File: rtl/alu_datapath.sv
module alu_datapath
  import acc_alu_pkg::*;
#(
  parameter int W   = 8,
  parameter int NIB = W / 2
) (
  input  logic [3:0]   op_code,
  input  logic [W-1:0] acc,
  input  logic [W-1:0] operand,
  input  logic         cy_in,
  output logic [W-1:0] result,
  output logic         acc_wr,
  output logic         flags_wr,
  output arith_flags_t flags
);

  logic         is_sub;
  logic [W-1:0] addend;
  logic [W:0]   carry;
  logic [W-1:0] sum;

  assign is_sub = (op_code == OP_SUBB);
  assign addend = is_sub ? ~operand : operand;

  always_comb begin
    if (op_code == OP_ADDC)      carry[0] = cy_in;
    else if (is_sub)             carry[0] = ~cy_in;
    else                         carry[0] = 1'b0;
  end

  // Ripple chain: every internal carry is visible for AC and OV
  for (genvar i = 0; i < W; i++) begin : g_chain
    assign sum[i]     = acc[i] ^ addend[i] ^ carry[i];
    assign carry[i+1] = (acc[i] & addend[i]) | (carry[i] & (acc[i] ^ addend[i]));
  end

  // Named events for checking
  logic ev_top_carry;
  logic ev_nib_carry;
  logic ev_sign_flip;
  assign ev_top_carry = carry[W];
  assign ev_nib_carry = carry[NIB];
  assign ev_sign_flip = carry[W] ^ carry[W-1];

  always_comb begin
    flags.cy = is_sub ? ~ev_top_carry : ev_top_carry;
    flags.ac = is_sub ? ~ev_nib_carry : ev_nib_carry;
    flags.ov = ev_sign_flip;
  end

  always_comb begin
    case (op_code)
      OP_ADD, OP_ADDC, OP_SUBB: result = sum;
      OP_AND:  result = acc & operand;
      OP_OR:   result = acc | operand;
      OP_XOR:  result = acc ^ operand;
      OP_INC:  result = acc + W'(1);
      OP_DEC:  result = acc - W'(1);
      OP_LOAD: result = operand;
      default: result = acc;
    endcase
  end

  assign acc_wr   = op_writes_acc(op_code);
  assign flags_wr = op_is_arith(op_code);

endmodule

// File: rtl/alu_status_reg.sv
module alu_status_reg
  import acc_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flags_wr,
  input  arith_flags_t flags_in,
  input  logic         bus_sw_we,
  input  logic [W-1:0] bus_wdata,
  input  logic [W-1:0] acc_now,
  output logic [W-1:0] sw_q,
  output logic [1:0]   bank_sel
);

  logic [W-1:1] held;
  logic [W-1:0] par_chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held <= '0;
    end else if (bus_sw_we) begin
      held <= bus_wdata[W-1:1];
    end else if (flags_wr) begin
      held[SW_CY] <= flags_in.cy;
      held[SW_AC] <= flags_in.ac;
      held[SW_OV] <= flags_in.ov;
    end
  end

  assign par_chain[0] = acc_now[0];
  for (genvar i = 1; i < W; i++) begin : g_par
    assign par_chain[i] = par_chain[i-1] ^ acc_now[i];
  end

  assign sw_q     = {held, par_chain[W-1]};
  assign bank_sel = {held[SW_BK1], held[SW_BK0]};

  // R6 R7
  flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_sw_we && !flags_wr) |=> (sw_q[W-1:1] == $past(sw_q[W-1:1])));

  // R10
  sw_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_sw_we |=> (sw_q[W-1:1] == $past(bus_wdata[W-1:1])));

  // R8
  parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_q[SW_P] == ($countones(acc_now) % 2 == 1));

endmodule

// File: rtl/alu_regs.sv
module alu_regs #(
  parameter int              W        = 8,
  parameter int              AW       = 8,
  parameter logic [AW-1:0]   SW_ADDR  = 8'hD0,
  parameter logic [AW-1:0]   ACC_ADDR = 8'hE0,
  parameter logic [AW-1:0]   B_ADDR   = 8'hF0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_wr,
  input  logic [W-1:0]  acc_next,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_we,
  input  logic [W-1:0]  bus_wdata,
  input  logic [W-1:0]  sw_in,
  output logic [W-1:0]  acc_q,
  output logic [W-1:0]  b_q,
  output logic [W-1:0]  bus_rdata,
  output logic          sw_we
);

  logic hit_acc, hit_b, hit_sw;
  assign hit_acc = (bus_addr == ACC_ADDR);
  assign hit_b   = (bus_addr == B_ADDR);
  assign hit_sw  = (bus_addr == SW_ADDR);
  assign sw_we   = bus_we && hit_sw;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else if (bus_we && hit_acc) begin
      acc_q <= bus_wdata;
    end else if (acc_wr) begin
      acc_q <= acc_next;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      b_q <= '0;
    end else if (bus_we && hit_b) begin
      b_q <= bus_wdata;
    end
  end

  always_comb begin
    if (hit_acc)     bus_rdata = acc_q;
    else if (hit_b)  bus_rdata = b_q;
    else if (hit_sw) bus_rdata = sw_in;
    else             bus_rdata = '0;
  end

  // R12
  bus_acc_prec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && hit_acc) |=> (acc_q == $past(bus_wdata)));

  // R9
  b_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && hit_b) |=> (b_q == $past(b_q)));

endmodule

// File: rtl/acc_alu_core.sv
module acc_alu_core
  import acc_alu_pkg::*;
#(
  parameter int            W        = 8,
  parameter int            AW       = 8,
  parameter logic [AW-1:0] SW_ADDR  = 8'hD0,
  parameter logic [AW-1:0] ACC_ADDR = 8'hE0,
  parameter logic [AW-1:0] B_ADDR   = 8'hF0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_valid,
  input  logic [3:0]    op_code,
  input  logic [W-1:0]  op_operand,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_we,
  input  logic [W-1:0]  bus_wdata,
  output logic [W-1:0]  bus_rdata,
  output logic [W-1:0]  acc_q,
  output logic [W-1:0]  b_q,
  output logic [W-1:0]  psw_q,
  output logic [1:0]    bank_sel
);

  logic [W-1:0] dp_result;
  logic         dp_acc_wr, dp_flags_wr;
  arith_flags_t dp_flags;
  logic         sw_we;

  alu_datapath #(.W(W)) u_dp (
    .op_code  (op_code),
    .acc      (acc_q),
    .operand  (op_operand),
    .cy_in    (psw_q[SW_CY]),
    .result   (dp_result),
    .acc_wr   (dp_acc_wr),
    .flags_wr (dp_flags_wr),
    .flags    (dp_flags)
  );

  alu_regs #(
    .W(W), .AW(AW), .SW_ADDR(SW_ADDR), .ACC_ADDR(ACC_ADDR), .B_ADDR(B_ADDR)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_wr    (op_valid && dp_acc_wr),
    .acc_next  (dp_result),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .sw_in     (psw_q),
    .acc_q     (acc_q),
    .b_q       (b_q),
    .bus_rdata (bus_rdata),
    .sw_we     (sw_we)
  );

  alu_status_reg #(.W(W)) u_sw (
    .clk       (clk),
    .rst_n     (rst_n),
    .flags_wr  (op_valid && dp_flags_wr),
    .flags_in  (dp_flags),
    .bus_sw_we (sw_we),
    .bus_wdata (bus_wdata),
    .acc_now   (acc_q),
    .sw_q      (psw_q),
    .bank_sel  (bank_sel)
  );

  logic bus_hits_acc_or_sw;
  assign bus_hits_acc_or_sw = bus_we && ((bus_addr == ACC_ADDR) || (bus_addr == SW_ADDR));

  // R2
  addc_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == OP_ADDC && !bus_hits_acc_or_sw)
      |=> (acc_q == $past(W'(acc_q + op_operand + W'(psw_q[SW_CY])))));

  // R7
  incdec_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && (op_code == OP_INC || op_code == OP_DEC) && !sw_we)
      |=> (psw_q[W-1:1] == $past(psw_q[W-1:1])));

  // R7
  idle_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_hits_acc_or_sw && (!op_valid || op_code > OP_LOAD))
      |=> (acc_q == $past(acc_q)));

endmodule

// File: tb/tb_acc_alu_core.sv
module tb_acc_alu_core;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       op_valid = 1'b0;
  logic [3:0] op_code = '0;
  logic [7:0] op_operand = '0;
  logic [7:0] bus_addr = '0;
  logic       bus_we = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata, acc_q, b_q, psw_q;
  logic [1:0] bank_sel;

  int checks = 0;
  int errors = 0;

  int m_a = 0, m_b = 0, m_up = 0;

  always #5 clk = ~clk;

  acc_alu_core dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .op_operand(op_operand), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .acc_q(acc_q), .b_q(b_q),
    .psw_q(psw_q), .bank_sel(bank_sel)
  );

  function automatic int par(input int v);
    int n = 0;
    for (int i = 0; i < 8; i++) n += (v >> i) & 1;
    return n & 1;
  endfunction

  function automatic int sx(input int v);
    return (v > 127) ? v - 256 : v;
  endfunction

  function automatic int m_psw();
    return m_up | par(m_a);
  endfunction

  function automatic int m_rd(input int addr);
    if (addr == 'hE0) return m_a;
    if (addr == 'hF0) return m_b;
    if (addr == 'hD0) return m_psw();
    return 0;
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %02h expected %02h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all(input string tag);
    chk(tag, "acc", int'(acc_q), m_a);
    chk(tag, "b", int'(b_q), m_b);
    chk(tag, "psw", int'(psw_q), m_psw());
    chk(tag, "bank_sel (R11)", int'(bank_sel), (m_up >> 3) & 3);
    chk(tag, "rdata (R9)", int'(bus_rdata), m_rd(int'(bus_addr)));
  endtask

  task automatic model_step(input int v, input int op, input int x,
                            input int we, input int addr, input int wd);
    int na = m_a, nb = m_b, nup = m_up;
    int c = (m_up >> 7) & 1;
    int cy = 0, ac = 0, ov = 0, s = 0, fl = 0;
    if (v != 0) begin
      case (op)
        0, 1: begin
          int ci = (op == 1) ? c : 0;
          s  = m_a + x + ci;
          cy = (s > 255) ? 1 : 0;
          ac = (((m_a & 15) + (x & 15) + ci) > 15) ? 1 : 0;
          s  = sx(m_a) + sx(x) + ci;
          ov = (s > 127 || s < -128) ? 1 : 0;
          na = (m_a + x + ci) & 255;
          fl = 1;
        end
        2: begin
          s  = m_a - x - c;
          cy = (s < 0) ? 1 : 0;
          ac = (((m_a & 15) - (x & 15) - c) < 0) ? 1 : 0;
          na = s & 255;
          s  = sx(m_a) - sx(x) - c;
          ov = (s > 127 || s < -128) ? 1 : 0;
          fl = 1;
        end
        3: na = m_a & x;
        4: na = m_a | x;
        5: na = m_a ^ x;
        6: na = (m_a + 1) & 255;
        7: na = (m_a + 255) & 255;
        8: na = x;
        default: ;
      endcase
      if (fl != 0) nup = (nup & 'h3B) | (cy << 7) | (ac << 6) | (ov << 2);
    end
    if (we != 0) begin
      if (addr == 'hE0) na = wd;
      if (addr == 'hF0) nb = wd;
      if (addr == 'hD0) nup = wd & 'hFE;
    end
    m_a = na; m_b = nb; m_up = nup;
  endtask

  // Drive at negedge, model the edge, compare at the following negedge
  task automatic step(input string tag, input int v, input int op, input int x,
                      input int we = 0, input int addr = 0, input int wd = 0);
    op_valid   = (v != 0);
    op_code    = 4'(op);
    op_operand = 8'(x);
    bus_we     = (we != 0);
    bus_addr   = 8'(addr);
    bus_wdata  = 8'(wd);
    model_step(v, op, x, we, addr, wd);
    @(posedge clk);
    @(negedge clk);
    compare_all(tag);
  endtask

  task automatic wr(input string tag, input int addr, input int wd);
    step(tag, 0, 0, 0, 1, addr, wd);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    compare_all("R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    compare_all("R1 after release");

    // Register bus map
    wr("R9 write B", 'hF0, 'h5A);
    bus_addr = 8'hF0; #1 chk("R9", "read B", int'(bus_rdata), 'h5A);
    wr("R9 unmapped write", 'h55, 'hAA);
    wr("R8 acc even", 'hE0, 'h03);
    wr("R8 acc odd", 'hE0, 'h07);

    // Add family
    wr("R2 setup", 'hE0, 'h7F);
    step("R4 R3 add 7F+01", 1, 0, 'h01);
    chk("R4", "ov set", int'(psw_q[2]), 1);
    wr("R2 setup", 'hE0, 'hFF);
    step("R2 R3 add FF+01", 1, 0, 'h01);
    chk("R2", "cy set", int'(psw_q[7]), 1);
    step("R2 addc with CY", 1, 1, 'h10);
    chk("R2", "acc 00+10+1", int'(acc_q), 'h11);

    // Subtract
    wr("R5 setup", 'hE0, 'h10);
    step("R3 subb nibble borrow", 1, 2, 'h01);
    chk("R3", "ac set", int'(psw_q[6]), 1);
    wr("R5 setup", 'hE0, 'h00);
    step("R5 subb 00-01", 1, 2, 'h01);
    chk("R5", "cy borrow", int'(psw_q[7]), 1);
    step("R5 subb with borrow", 1, 2, 'h00);
    wr("R4 setup", 'hE0, 'h80);
    step("R4 subb 80-01", 1, 2, 'h01);

    // Logic ops with flags preset
    wr("R6 preset flags", 'hD0, 'hE4);
    step("R6 and", 1, 3, 'h0F);
    step("R6 or", 1, 4, 'hC0);
    step("R6 xor", 1, 5, 'hFF);

    // Inc/dec/load and reserved codes
    wr("R7 setup", 'hE0, 'hFF);
    step("R7 inc wrap", 1, 6, 0);
    step("R7 dec wrap", 1, 7, 0);
    step("R7 load", 1, 8, 'h3C);
    step("R7 reserved op 12", 1, 12, 'h99);
    step("R7 idle strobe low", 0, 0, 'h99);

    // Status word writes and bank select
    wr("R10 sw write FF", 'hD0, 'hFF);
    wr("R11 sw write 08", 'hD0, 'h08);
    wr("R10 sw write 01", 'hD0, 'h01);

    // Precedence
    step("R12 acc bus beats add", 1, 0, 'h01, 1, 'hE0, 'h42);
    step("R12 sw bus beats add flags", 1, 0, 'hFF, 1, 'hD0, 'h10);
    step("R12 b write with op", 1, 6, 0, 1, 'hF0, 'h77);

    // Mixed patterns
    for (int i = 0; i < 400; i++) begin
      int r = (i * 37 + 11) % 256;
      int op = (i * 7 + 3) % 11;
      int we = ((i % 9) == 0) ? 1 : 0;
      int ad = ((i % 3) == 0) ? 'hD0 : (((i % 3) == 1) ? 'hE0 : 'hF0);
      step("R2 R3 R4 R5 R6 R7 mixed", 1, op, r, we, ad, (r * 5) & 255);
    end

    rst_n = 1'b0;
    m_a = 0; m_b = 0; m_up = 0;
    #1 compare_all("R1 reassert");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule